// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an 8-bit general-purpose I/O port that a processor controls through a small register interface. Each bit has a direction bit and an output data bit. When the direction bit is set, the block drives the stored output value onto the pin and enables the pin's driver. When the direction bit is clear, the pin is an input. The pin is then sampled through a two-flop synchroniser so that software can read it.

Only bits 7 to 3 and bit 0 exist. Bits 2 and 1 have no storage and are never driven. When the mode input selects the clock mode, setting direction bit 7 drives the system clock onto pin 7 instead of the stored data bit. A hardware standby input returns both registers to their reset values. A software standby input freezes the registers and the sampled pin levels.

The bus has an 8-bit data path, a one-cycle write strobe and combinational read data. The offsets are: 0 for direction (write-only), 1 for output data (read/write) and 2 for pin state (read-only).

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the direction and data registers are 0. pin_oe is 0, and a read of offset 1 returns 0.
- R2: Writing 1 to a direction bit (offset 0) sets pin_oe for that bit. pin_out then carries the data register bit, which is written at offset 1.
- R3: Bits 2 and 1 are never driven (pin_oe is 0). They read as 0 at every offset, and writes to them are discarded.
- R4: When mode equals 7 and direction bit 7 is 1, pin_out[7] follows the clock (high while clk is high, low while clk is low). In any other mode, pin_out[7] equals data bit 7.
- R5: A read of offset 2 returns, per implemented bit, the data register bit when its direction bit is 1, and the synchronised pin level when its direction bit is 0.
- R6: A write to offset 2 changes neither the direction register nor the data register.
- R7: While hw_stby is high at a clock edge, both registers clear to 0 and writes are ignored. The pin synchroniser keeps sampling.
- R8: While sw_stby is high (and hw_stby is low), both registers hold and writes are ignored. The synchronised pin levels also hold, and resume updating once sw_stby falls.
- R9: A change on pin_in shows in an offset-2 read after exactly two rising clock edges, and not after one.
- R10: A read of offset 0 or offset 3 returns 0.
- R11: A read of offset 1 returns the last value written to the data register, with bits 2 and 1 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source routed to pin 7 in clock mode |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: registers are reinitialised |
| sw_stby | input | 1 | Software standby: registers and sampled pins hold |
| mode | input | 3 | Operating mode; value 7 enables the clock output on bit 7 |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
A register write becomes visible one rising edge after the strobe. The bench therefore raises the strobe at a falling edge, drops it at the next falling edge, and reads back there. A pin change needs two rising edges. The bench checks the offset-2 read one falling edge after the change, expecting the old value, and again at the second falling edge, expecting the new value. The clock routed to pin 7 is sampled shortly after a rising edge and again shortly after a falling edge, so both of its levels are checked.

// File: rtl/gpio_port_pkg.sv
// Shared constants for the GPIO port: register offsets and mode code.
package gpio_port_pkg;
    localparam int            ADDR_W   = 2;
    localparam logic [1:0]    OFS_DIR  = 2'd0;
    localparam logic [1:0]    OFS_DATA = 2'd1;
    localparam logic [1:0]    OFS_PIN  = 2'd2;
    localparam int            MODE_W   = 3;
    localparam logic [2:0]    CLK_MODE = 3'd7;
endpackage

// File: rtl/gpio_port_sync.sv
// Two-flop synchroniser for the pin inputs.
// Assumes: pins are asynchronous to clk. While hold is high, both stages
// keep their contents (software standby).
module gpio_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Purpose: move pin levels two stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else if (!hold) begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold ##1 !hold) |=> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
// Direction and output data registers of the GPIO port.
// Assumes: MASK marks implemented bits; others have no flop and read 0.
// Priority: reset, then hardware standby (clear), then software standby (hold).
module gpio_port_regs #(
    parameter int         W    = 8,
    parameter logic [W-1:0] MASK = 8'hF9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic         wr_dir,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            // Purpose: per-bit direction/data storage with standby rules.
            always_ff @(posedge clk) begin
                if (!rst_n || hw_stby) begin
                    dir_q[i]  <= 1'b0;
                    data_q[i] <= 1'b0;
                end else if (!sw_stby) begin
                    if (wr_dir)  dir_q[i]  <= wdata[i];
                    if (wr_data) data_q[i] <= wdata[i];
                end
            end
        end else begin : g_none
            assign dir_q[i]  = 1'b0;
            assign data_q[i] = 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && data_q == '0));

    // R7
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == '0 && data_q == '0));

    // R8
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/gpio_port.sv
// GPIO port top: bus decode, readback mux, pin drive with the clock option.
// Assumes: bus_rdata is combinational; a write strobe lasts one cycle.
module gpio_port #(
    parameter int           W         = 8,
    parameter logic [W-1:0] IMPL_MASK = 8'hF9,
    parameter int           CLK_BIT   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic [2:0]   mode,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    import gpio_port_pkg::*;

    logic [W-1:0] dir_q, data_q, pin_sync, rd_raw;
    logic         wr_dir, wr_data, sync_hold, clk_sel;

    // Purpose: decode the write strobe into per-register enables.
    always_comb begin
        wr_dir  = bus_wr && (bus_addr == OFS_DIR);
        wr_data = bus_wr && (bus_addr == OFS_DATA);
    end

    assign sync_hold = sw_stby && !hw_stby;

    gpio_port_regs #(.W(W), .MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .wr_dir(wr_dir), .wr_data(wr_data), .wdata(bus_wdata),
        .dir_q(dir_q), .data_q(data_q)
    );

    gpio_port_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .hold(sync_hold), .d(pin_in), .q(pin_sync)
    );

    // Purpose: select read data by offset; pin offset merges per bit.
    always_comb begin
        case (bus_addr)
            OFS_DATA: rd_raw = data_q;
            OFS_PIN:  rd_raw = (dir_q & data_q) | (~dir_q & pin_sync);
            default:  rd_raw = '0;
        endcase
        bus_rdata = rd_raw & IMPL_MASK;
    end

    assign pin_oe  = dir_q;
    assign clk_sel = (mode == CLK_MODE);

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == CLK_BIT && IMPL_MASK[i]) begin : g_clk
            assign pin_out[i] = (clk_sel && dir_q[i]) ? clk : data_q[i];
        end else begin : g_dat
            assign pin_out[i] = data_q[i];
        end
    end

    // R3
    unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~IMPL_MASK) == '0) && ((bus_rdata & ~IMPL_MASK) == '0));

    // R10
    dir_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_DIR || bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] M = 8'hF9;

    logic       clk = 1'b0;
    logic       rst_n, hw_stby, sw_stby, bus_wr;
    logic [2:0] mode;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, pin_in, pin_oe, pin_out;
    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .mode(mode), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, v);
        check("R1 data", v, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
    endtask

    task automatic t_drive();
        logic [7:0] v;
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'hFF);
        check("R2 oe", pin_oe, M);
        check("R2 out", pin_out & M, 8'hA5 & M);
        rd(2'd1, v);
        check("R11 data read", v, 8'hA1);
        wr(2'd0, 8'h09);
        check("R2 oe partial", pin_oe, 8'h09);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        wr(2'd1, 8'h06);
        rd(2'd1, v);
        check("R3 data bits", v, 8'h00);
        wr(2'd0, 8'h06);
        check("R3 oe", pin_oe, 8'h00);
        pin_in = 8'h06;
        repeat (3) @(negedge clk);
        rd(2'd2, v);
        check("R3 pin read", v, 8'h00);
    endtask

    task automatic t_clock();
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h80);
        mode = 3'd7;
        @(posedge clk); #1;
        check("R4 clk high", {7'd0, pin_out[7]}, 8'h01);
        @(negedge clk); #1;
        check("R4 clk low", {7'd0, pin_out[7]}, 8'h00);
        mode = 3'd3;
        wr(2'd1, 8'h80);
        @(posedge clk); #1;
        check("R4 data mode hi", {7'd0, pin_out[7]}, 8'h01);
        @(negedge clk); #1;
        check("R4 data mode lo", {7'd0, pin_out[7]}, 8'h01);
    endtask

    task automatic t_pinread();
        logic [7:0] v;
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'hC1);
        @(negedge clk);
        pin_in = 8'h39;
        repeat (2) @(negedge clk);
        rd(2'd2, v);
        check("R5 mixed", v, 8'hF9 & ((8'hC1 & 8'hF0) | (~8'hC1 & 8'h39)));
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        @(negedge clk);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h88;
        @(negedge clk);
        rd(2'd2, v);
        check("R9 one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd2, v);
        check("R9 two edges", v, 8'h88);
    endtask

    task automatic t_pin_wr();
        logic [7:0] v;
        wr(2'd1, 8'h11);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'hFF);
        rd(2'd1, v);
        check("R6 data", v, 8'h11);
        check("R6 dir", pin_oe, 8'h01);
    endtask

    task automatic t_dir_read();
        logic [7:0] v;
        rd(2'd0, v);
        check("R10 dir read", v, 8'h00);
        rd(2'd3, v);
        check("R10 ofs3 read", v, 8'h00);
    endtask

    task automatic t_sw();
        logic [7:0] v;
        wr(2'd1, 8'h50);
        wr(2'd0, 8'h18);
        @(negedge clk);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        sw_stby = 1'b1;
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        rd(2'd1, v);
        check("R8 data held", v, 8'h50);
        check("R8 dir held", pin_oe, 8'h18);
        pin_in = 8'hE1;
        repeat (3) @(negedge clk);
        rd(2'd2, v);
        check("R8 pins frozen", v, 8'h10);
        sw_stby = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd2, v);
        check("R8 pins resume", v, 8'hF9 & ((8'h50 & 8'h18) | (~8'h18 & 8'hE1)));
    endtask

    task automatic t_hw();
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        hw_stby = 1'b1;
        @(negedge clk);
        rd(2'd1, v);
        check("R7 data clear", v, 8'h00);
        check("R7 dir clear", pin_oe, 8'h00);
        wr(2'd1, 8'h80);
        rd(2'd1, v);
        check("R7 write ignored", v, 8'h00);
        pin_in = 8'h41;
        repeat (2) @(negedge clk);
        rd(2'd2, v);
        check("R7 pins sampled", v, 8'h41);
        hw_stby = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; mode = 3'd0;
        bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00; pin_in = 8'h00;
        t_reset();
        t_drive();
        t_unimpl();
        t_clock();
        t_pinread();
        t_sync();
        t_pin_wr();
        t_dir_read();
        t_sw();
        t_hw();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule